// File: doc/BRIEF.md
# Paired-Wire First-Arrival Separator

Two neighbouring drift cells share a wire path: the far ends of their wires are joined through a delay element. A single ionisation pulse therefore appears on both discriminator outputs, first on the cell that was actually hit and later on its partner. This block takes the two discriminator outputs as asynchronous inputs and samples them with a 53 MHz clock. It works out which one rose first and emits one trigger pulse tagged to that wire. The partner's later pulse is suppressed.

Each input passes through a synchronizer and a rising-edge detector. A shared arbiter then accepts the first detected edge. After any decision the arbiter ignores both channels for a hold-off of `ceil(WINDOW_NS * CLK_MHZ / 1000)` clock cycles, which is 4 cycles at the default 60 ns and 53 MHz. It then re-arms both channels. Two edges detected in the same cycle cannot be told apart. In that case no trigger is emitted, an ambiguity pulse is raised instead, and the same hold-off follows.

Top module: `wire_pair_separator`

## Requirements
- R1: While `rst` is high, and afterwards while both inputs stay low, `trig_a`, `trig_b` and `ambig` are all 0.
- R2: With the arbiter armed, suppose an input is first sampled high at clock edge n after having been sampled low at edge n-1. Then its trigger output goes high at edge n+2.
- R3: Every output pulse lasts exactly one clock cycle, even when the input stays high for many cycles.
- R4: If the edge on `wire_a_in` is detected before the edge on `wire_b_in`, only `trig_a` fires. A `wire_b_in` edge detected within the hold-off gives no output.
- R5: The same holds with the channels swapped: an earlier `wire_b_in` edge fires only `trig_b` and vetoes `wire_a_in`.
- R6: If both edges are detected in the same cycle, neither trigger fires and `ambig` is high for one cycle.
- R7: After a trigger, edges detected in the next HOLD_CYCLES cycles (4 by default) are ignored on both channels, including the winner's own channel. An edge detected in cycle HOLD_CYCLES+1 is accepted.
- R8: The hold-off of R7 also follows an `ambig` pulse.
- R9: At most one of `trig_a`, `trig_b`, `ambig` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (nominally 53 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| wire_a_in | input | 1 | Asynchronous discriminator output of wire A |
| wire_b_in | input | 1 | Asynchronous discriminator output of wire B |
| trig_a | output | 1 | One-cycle trigger: wire A was hit first |
| trig_b | output | 1 | One-cycle trigger: wire B was hit first |
| ambig | output | 1 | One-cycle flag: both edges seen in the same cycle |

## Verification
The bench aims at the exact end of the hold-off. It places a retrigger in the fourth cycle after a decision and another in the fifth. An off-by-one counter would either accept the first or drop the second. It also drives edges detected in the same cycle: an arbiter with a fixed priority would emit a trigger there instead of the ambiguity flag. Long input levels are used too, so that a level-sensitive design would emit repeated pulses. Random overlapping pulse trains on both channels then exercise the veto from either side against a cycle-level model of the requirements.

// File: rtl/wps_pkg.sv
package wps_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_HOLD = 2'd1
  } arb_state_t;

  typedef struct packed {
    logic fire_a;
    logic fire_b;
    logic tie;
  } arb_out_t;

  function automatic int hold_cycles(input int window_ns, input int clk_mhz);
    return (window_ns * clk_mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/wps_edge_sync.sv
module wps_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  // STAGES synchronizer flops plus one history flop for edge detection
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
    end else begin
      shift_q <= {shift_q[DEPTH-2:0], async_in};
    end
  end

  assign rise = shift_q[STAGES-1] & ~shift_q[STAGES];

endmodule

// File: rtl/wps_arbiter.sv
module wps_arbiter
  import wps_pkg::*;
#(
  parameter int HOLD_CYCLES = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     rise_a,
  input  logic     rise_b,
  output arb_out_t out_q
);
  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

  arb_state_t     state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ARB_IDLE;
      cnt_q   <= '0;
      out_q   <= '0;
    end else begin
      out_q <= '0;
      unique case (state_q)
        ARB_IDLE: begin
          if (rise_a || rise_b) begin
            out_q.fire_a <= rise_a & ~rise_b;
            out_q.fire_b <= rise_b & ~rise_a;
            out_q.tie    <= rise_a & rise_b;
            cnt_q        <= '0;
            state_q      <= ARB_HOLD;
          end
        end
        ARB_HOLD: begin
          if (cnt_q == CNT_LAST) begin
            state_q <= ARB_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ARB_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wire_pair_separator.sv
module wire_pair_separator
  import wps_pkg::*;
#(
  parameter int CLK_MHZ     = 53,
  parameter int WINDOW_NS   = 60,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wire_a_in,
  input  logic wire_b_in,
  output logic trig_a,
  output logic trig_b,
  output logic ambig
);
  localparam int HOLD_CYCLES = hold_cycles(WINDOW_NS, CLK_MHZ);
  localparam int NCH = 2;

  logic [NCH-1:0] raw_in;
  logic [NCH-1:0] rise;
  logic           rise_a;
  logic           rise_b;
  arb_out_t       arb_q;

  assign raw_in = {wire_b_in, wire_a_in};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    wps_edge_sync #(
      .STAGES(SYNC_STAGES)
    ) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (raw_in[ch]),
      .rise     (rise[ch])
    );
  end

  assign rise_a = rise[0];
  assign rise_b = rise[1];

  wps_arbiter #(
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_arb (
    .clk    (clk),
    .rst    (rst),
    .rise_a (rise_a),
    .rise_b (rise_b),
    .out_q  (arb_q)
  );

  assign trig_a = arb_q.fire_a;
  assign trig_b = arb_q.fire_b;
  assign ambig  = arb_q.tie;

endmodule

// File: rtl/wps_checker.sv
module wps_checker #(
  parameter int HOLD_CYCLES = 4
) (
  input logic clk,
  input logic rst,
  input logic rise_a,
  input logic rise_b,
  input logic trig_a,
  input logic trig_b,
  input logic ambig
);
  localparam int GAP_W = $clog2(HOLD_CYCLES + 2);
  localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(HOLD_CYCLES);

  logic             any_out;
  logic [GAP_W-1:0] gap_q;

  assign any_out = trig_a | trig_b | ambig;

  // cycles elapsed since the last output pulse, saturating at HOLD_CYCLES
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= GAP_MIN;
    end else if (any_out) begin
      gap_q <= '0;
    end else if (gap_q < GAP_MIN) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R9: outputs are mutually exclusive
  p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({trig_a, trig_b, ambig}));

  // R3: single-cycle pulses
  p_pulse_a_r3: assert property (@(posedge clk) disable iff (rst)
    trig_a |=> !trig_a);
  p_pulse_b_r3: assert property (@(posedge clk) disable iff (rst)
    trig_b |=> !trig_b);

  // R2: a trigger follows a detected edge on its own channel
  p_latency_a_r2: assert property (@(posedge clk) disable iff (rst)
    trig_a |-> $past(rise_a));
  p_latency_b_r2: assert property (@(posedge clk) disable iff (rst)
    trig_b |-> $past(rise_b));

  // R4 / R5: winner had no competing edge in the same cycle
  p_first_a_r4: assert property (@(posedge clk) disable iff (rst)
    trig_a |-> $past(!rise_b));
  p_first_b_r5: assert property (@(posedge clk) disable iff (rst)
    trig_b |-> $past(!rise_a));

  // R6: ambiguity only from simultaneous edges
  p_tie_r6: assert property (@(posedge clk) disable iff (rst)
    ambig |-> $past(rise_a && rise_b));

  // R7 / R8: no output inside the hold-off window after any output
  p_holdoff_r7: assert property (@(posedge clk) disable iff (rst)
    any_out |-> (gap_q >= GAP_MIN));

endmodule

bind wire_pair_separator wps_checker #(
  .HOLD_CYCLES(HOLD_CYCLES)
) u_wps_chk (
  .clk    (clk),
  .rst    (rst),
  .rise_a (rise_a),
  .rise_b (rise_b),
  .trig_a (trig_a),
  .trig_b (trig_b),
  .ambig  (ambig)
);

// File: tb/sim_wire_pair_separator.sv
`timescale 1ns/1ps
module sim_wire_pair_separator;
  localparam int HOLD = 4;  // ceil(60 ns * 53 MHz)

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wa = 1'b0;
  logic wb = 1'b0;
  logic trig_a, trig_b, ambig;

  int checks = 0;
  int errors = 0;

  bit [4:0] ha = '0;   // ha[k]: wire A value driven k+1 steps ago
  bit [4:0] hb = '0;
  int hc = 0;          // model hold-off remaining
  string phase = "R1";

  always #10 clk = ~clk;  // 50 MHz

  wire_pair_separator u0 (
    .clk(clk), .rst(rst), .wire_a_in(wa), .wire_b_in(wb),
    .trig_a(trig_a), .trig_b(trig_b), .ambig(ambig)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // One negedge step: compare outputs to the model, then drive new inputs.
  task automatic step(bit na, bit nb);
    bit ea, eb, xa, xb, xm;
    @(negedge clk);
    ea = ha[2] & ~ha[3];
    eb = hb[2] & ~hb[3];
    xa = 0; xb = 0; xm = 0;
    if (hc > 0) hc--;
    else if (ea && eb) begin xm = 1; hc = HOLD; end
    else if (ea) begin xa = 1; hc = HOLD; end
    else if (eb) begin xb = 1; hc = HOLD; end
    chk(phase, "trig_a", trig_a, xa);
    chk(phase, "trig_b", trig_b, xb);
    chk(phase, "ambig", ambig, xm);
    chk("R9", "exclusive", logic'($onehot0({trig_a, trig_b, ambig})), 1'b1);
    wa = na; wb = nb;
    ha = {ha[3:0], na};
    hb = {hb[3:0], nb};
  endtask

  task automatic seq(string tag, bit [15:0] pa, bit [15:0] pb, int len);
    phase = tag;
    for (int k = 0; k < len; k++) step(pa[k], pb[k]);
    for (int k = 0; k < 10; k++) step(1'b0, 1'b0);
  endtask

  initial begin
    int la, lb, sa, sb;
    bit va, vb;
    void'($urandom(32'h5EED_0042));
    // R1: reset state
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R1", "trig_a", trig_a, 1'b0);
      chk("R1", "trig_b", trig_b, 1'b0);
      chk("R1", "ambig", ambig, 1'b0);
    end
    @(negedge clk);
    rst = 1'b0;
    phase = "R1";
    for (int k = 0; k < 6; k++) step(1'b0, 1'b0);

    // R2: single clean pulse on A, latency from the model
    seq("R2", 16'h00F0, 16'h0000, 12);
    // R3: long level on B gives one pulse
    seq("R3", 16'h0000, 16'hFFF0, 16);
    // R4: A first, B one cycle later
    seq("R4", 16'h00F0, 16'h01E0, 12);
    // R5: B first, A two cycles later
    seq("R5", 16'h03C0, 16'h00F0, 12);
    // R6: simultaneous edges
    seq("R6", 16'h00F0, 16'h00F0, 12);
    // R7: A retrigger detected 4 cycles later (ignored)
    seq("R7", 16'b0000_0001_0001, 16'h0000, 12);
    // R7: A retrigger detected 5 cycles later (accepted)
    seq("R7", 16'b0000_0010_0001, 16'h0000, 12);
    // R7: B edge 4 cycles after A win (ignored), then 5 (accepted)
    seq("R7", 16'h0003, 16'h0010, 12);
    seq("R7", 16'h0003, 16'h0020, 12);
    // R8: hold-off after tie, B at 4 then 5 cycles
    seq("R8", 16'h0001, 16'b0001_0001, 12);
    seq("R8", 16'h0001, 16'b0010_0001, 12);

    // random overlapping pulse trains
    phase = "R4,R5,R7";
    la = 0; lb = 0; va = 0; vb = 0; sa = 0; sb = 0;
    for (int k = 0; k < 4000; k++) begin
      if (la == 0) begin va = ~va; la = va ? 3 + int'($urandom_range(5)) : 1 + int'($urandom_range(10)); end
      if (lb == 0) begin vb = ~vb; lb = vb ? 3 + int'($urandom_range(5)) : 1 + int'($urandom_range(10)); end
      la--; lb--;
      sa += int'(va); sb += int'(vb);
      step(va, vb);
    end
    phase = "R4,R5,R7";
    for (int k = 0; k < 12; k++) step(1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule